// File: doc/BRIEF.md
# Configurable Multi-Function GPIO Port

This block is a 16-pin general-purpose I/O port with its own per-pin register set. For each pin, software chooses the direction, whether the pin is owned by the port's own output latch or by a peripheral, which of up to four peripherals owns it, and whether the output stage is push-pull or open-drain. The pad side gets a registered output value and a registered output enable for every pin. Pad inputs pass through a two-flop synchronizer. The synchronized levels then feed both the read path and a shared input vector that goes back to the peripherals.

A simple register bus with write, read and byte enables gives access to the configuration and to the output latch. Two extra write-only addresses set or clear latch bits. They do this as a read-modify-write of the port's read value, the same way a bit-manipulation sequence on the port would. So a set or clear on a port with mixed directions copies the current pin level into the latch bits of the input pins.

Top module: `gpio_port`

## Requirements
- R1: The direction register resets to all ones, so every pin is an input. For a pin in port role with push-pull output, direction bit 0 drives pad_oe high and direction bit 1 holds pad_oe low. The direction register is at offset 1.
- R2: The role register (offset 2) resets to 0, which is port role. When a pin's role bit is 1, that pin's pad value and enable come from the selected peripheral, and the latch and direction bit are ignored.
- R3: For each pin, the peripheral is selected by {select-high bit (offset 4), select-low bit (offset 3)}: 0 selects periph_out/periph_oe slice 0 (bits 15:0), and so on up to 3 (bits 63:48). Both select registers reset to 0.
- R4: When a pin's open-drain bit (offset 5) is 1, pad_out is 0, and pad_oe is high only when the pin's enable is high and its value is 0. This applies in both port and peripheral role. The open-drain register resets to 0.
- R5: The data latch (offset 0) resets to 0. On a write, bus_be[0] enables bits 7:0 and bus_be[1] enables bits 15:8. Disabled bytes keep their value. Byte enables apply in the same way to writes at offsets 1 to 5.
- R6: A read at offset 0 returns, for each pin, the latch bit when the direction bit is 0 and the synchronized pad level when it is 1. Offsets 1 to 5 read back their registers, and offsets 6 and 7 read as 0.
- R7: A write at offset 6 loads the latch with (port read value OR wdata). A write at offset 7 loads it with (port read value AND NOT wdata). In both cases, input pins take their current synchronized pad level.
- R8: pad_in reaches periph_in and the read path through two flops. A change set up before clock edge k shows on periph_in after edge k+1.
- R9: pad_out and pad_oe are registered. They change at the clock edge after the edge that writes the register. bus_rdata updates at the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables for writes |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| periph_out | input | 64 | Output values of four peripherals, 16 bits each |
| periph_oe | input | 64 | Output enables of four peripherals, 16 bits each |
| periph_in | output | 16 | Synchronized pad levels returned to peripherals |

## Verification
Four things are checked by assertions on every cycle: an open-drain pin never drives high, an input pin in port role never has its enable asserted, the synchronizer delay matches the pad history, and the set and clear writes force the addressed latch bits. Other behaviours can only be shown by the bench scenarios. These are the choice among the four peripherals, byte-merging of writes, the split read value on a port with mixed directions, and the latch of an input pin picking up its pad level during a set or clear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_ROLE  = 3'd2,
    REG_FSEL0 = 3'd3,
    REG_FSEL1 = 3'd4,
    REG_ODRN  = 3'd5,
    REG_DSET  = 3'd6,
    REG_DCLR  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    AST_SYNC_TWO_FLOP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(async_in, 2))); // R8
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH/8-1:0] be,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  role_q,
  output logic [WIDTH-1:0]  fsel0_q,
  output logic [WIDTH-1:0]  fsel1_q,
  output logic [WIDTH-1:0]  odrn_q,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  rdata_q
);
  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] byte_mask;
  logic [WIDTH-1:0] port_view;
  logic [WIDTH-1:0] rd_mux;
  reg_sel_e         sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign byte_mask[b*8 +: 8] = {8{be[b]}};
  end

  assign sel       = reg_sel_e'(addr);
  assign port_view = (latch_q & ~dir_q) | (pin_sync & dir_q);

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old_v,
                                             input logic [WIDTH-1:0] new_v,
                                             input logic [WIDTH-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '1;
      role_q  <= '0;
      fsel0_q <= '0;
      fsel1_q <= '0;
      odrn_q  <= '0;
      latch_q <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_DATA:  latch_q <= merge(latch_q, wdata, byte_mask);
        REG_DIR:   dir_q   <= merge(dir_q,   wdata, byte_mask);
        REG_ROLE:  role_q  <= merge(role_q,  wdata, byte_mask);
        REG_FSEL0: fsel0_q <= merge(fsel0_q, wdata, byte_mask);
        REG_FSEL1: fsel1_q <= merge(fsel1_q, wdata, byte_mask);
        REG_ODRN:  odrn_q  <= merge(odrn_q,  wdata, byte_mask);
        REG_DSET:  latch_q <= port_view | wdata;
        REG_DCLR:  latch_q <= port_view & ~wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_DATA:  rd_mux = port_view;
      REG_DIR:   rd_mux = dir_q;
      REG_ROLE:  rd_mux = role_q;
      REG_FSEL0: rd_mux = fsel0_q;
      REG_FSEL1: rd_mux = fsel1_q;
      REG_ODRN:  rd_mux = odrn_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_DSET) |=> ((latch_q & $past(wdata)) == $past(wdata))); // R7
  AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_DCLR) |=> ((latch_q & $past(wdata)) == '0)); // R7
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH = 16,
  parameter int NFUNC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WIDTH-1:0]       dir_q,
  input  logic [WIDTH-1:0]       role_q,
  input  logic [WIDTH-1:0]       fsel0_q,
  input  logic [WIDTH-1:0]       fsel1_q,
  input  logic [WIDTH-1:0]       odrn_q,
  input  logic [WIDTH-1:0]       latch_q,
  input  logic [NFUNC*WIDTH-1:0] periph_out,
  input  logic [NFUNC*WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0]       pad_out_q,
  output logic [WIDTH-1:0]       pad_oe_q
);
  localparam int SEL_SPAN = 4;

  logic [WIDTH-1:0] fn_out [SEL_SPAN];
  logic [WIDTH-1:0] fn_oe  [SEL_SPAN];
  logic [WIDTH-1:0] val_nxt, en_nxt, out_nxt, oe_nxt;

  for (genvar f = 0; f < SEL_SPAN; f++) begin : g_fn
    if (f < NFUNC) begin : g_live
      assign fn_out[f] = periph_out[f*WIDTH +: WIDTH];
      assign fn_oe[f]  = periph_oe[f*WIDTH +: WIDTH];
    end else begin : g_idle
      assign fn_out[f] = '0;
      assign fn_oe[f]  = '0;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [1:0] sel;
    logic       p_val, p_en;
    assign sel   = {fsel1_q[i], fsel0_q[i]};
    assign p_val = fn_out[sel][i];
    assign p_en  = fn_oe[sel][i];
    assign val_nxt[i] = role_q[i] ? p_val : latch_q[i];
    assign en_nxt[i]  = role_q[i] ? p_en  : ~dir_q[i];
    assign out_nxt[i] = odrn_q[i] ? 1'b0 : val_nxt[i];
    assign oe_nxt[i]  = odrn_q[i] ? (en_nxt[i] & ~val_nxt[i]) : en_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_q <= '0;
      pad_oe_q  <= '0;
    end else begin
      pad_out_q <= out_nxt;
      pad_oe_q  <= oe_nxt;
    end
  end

  AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe_q & pad_out_q & $past(odrn_q)) == '0)); // R4
  AST_INPUT_PIN_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe_q & $past(dir_q & ~role_q)) == '0)); // R1
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NFUNC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [WIDTH-1:0]       bus_wdata,
  input  logic [WIDTH/8-1:0]     bus_be,
  output logic [WIDTH-1:0]       bus_rdata,
  input  logic [WIDTH-1:0]       pad_in,
  output logic [WIDTH-1:0]       pad_out,
  output logic [WIDTH-1:0]       pad_oe,
  input  logic [NFUNC*WIDTH-1:0] periph_out,
  input  logic [NFUNC*WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0]       periph_in
);
  localparam int SYNC_STAGES = 2;

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q, role_q, fsel0_q, fsel1_q, odrn_q, latch_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .pin_sync(pin_sync),
    .dir_q(dir_q), .role_q(role_q), .fsel0_q(fsel0_q), .fsel1_q(fsel1_q),
    .odrn_q(odrn_q), .latch_q(latch_q), .rdata_q(bus_rdata)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .NFUNC(NFUNC)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .role_q(role_q),
    .fsel0_q(fsel0_q), .fsel1_q(fsel1_q), .odrn_q(odrn_q), .latch_q(latch_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out_q(pad_out), .pad_oe_q(pad_oe)
  );

  assign periph_in = pin_sync;
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_rdata, pad_out, pad_oe, periph_in;
  logic [15:0] pad_in = '0;
  logic [63:0] periph_out = {16'h5555, 16'h3333, 16'h0F0F, 16'h00FF};
  logic [63:0] periph_oe  = {16'hF0F0, 16'h00FF, 16'hFF00, 16'hFFFF};

  int total = 0;
  int bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in)
  );

  // {dir, role, fsel0, fsel1, odrn, latch, exp_out, exp_oe}
  localparam logic [127:0] VECS [0:9] = '{
    {16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'hA5C3, 16'hA5C3,16'hFFFF}, // R1 all out
    {16'hFF00,16'h0000,16'h0000,16'h0000,16'h0000,16'h1234, 16'h1234,16'h00FF}, // R1 mixed
    {16'hFFFF,16'hFFFF,16'h0000,16'h0000,16'h0000,16'h0000, 16'h00FF,16'hFFFF}, // R2 R3 fn0
    {16'hFFFF,16'hFFFF,16'hFFFF,16'h0000,16'h0000,16'h0000, 16'h0F0F,16'hFF00}, // R3 fn1
    {16'hFFFF,16'hFFFF,16'h0000,16'hFFFF,16'h0000,16'h0000, 16'h3333,16'h00FF}, // R3 fn2
    {16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'h0000,16'h0000, 16'h5555,16'hF0F0}, // R3 fn3
    {16'h0000,16'h0000,16'h0000,16'h0000,16'hFFFF,16'h00F0, 16'h0000,16'hFF0F}, // R4 port
    {16'h0000,16'h00FF,16'h0000,16'h0000,16'h0000,16'hAB00, 16'hABFF,16'hFFFF}, // R2 split
    {16'hFFFF,16'hFFFF,16'hFF00,16'hF0F0,16'h0000,16'h0000, 16'h5F3F,16'hFFFF}, // R3 mixed
    {16'hFFFF,16'hFFFF,16'h0000,16'h0000,16'hFFFF,16'h0000, 16'h0000,16'hFF00}  // R4 periph
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step();
    // reset state
    chk(pad_oe, 16'h0000, "R1 reset pad_oe");
    chk(pad_out, 16'h0000, "R5 reset pad_out");
    rd(3'd1, rv); chk(rv, 16'hFFFF, "R1 reset dir");
    rd(3'd2, rv); chk(rv, 16'h0000, "R2 reset role");
    rd(3'd3, rv); chk(rv, 16'h0000, "R3 reset fsel0");
    rd(3'd4, rv); chk(rv, 16'h0000, "R3 reset fsel1");
    rd(3'd5, rv); chk(rv, 16'h0000, "R4 reset odrn");
    wr(3'd1, 16'h0000);
    rd(3'd0, rv); chk(rv, 16'h0000, "R5 reset latch");

    // vector table
    for (int v = 0; v < 10; v++) begin
      wr(3'd1, VECS[v][127:112]);
      wr(3'd2, VECS[v][111:96]);
      wr(3'd3, VECS[v][95:80]);
      wr(3'd4, VECS[v][79:64]);
      wr(3'd5, VECS[v][63:48]);
      wr(3'd0, VECS[v][47:32]);
      step();
      chk(pad_out, VECS[v][31:16], $sformatf("R1-table vec%0d pad_out", v));
      chk(pad_oe,  VECS[v][15:0],  $sformatf("R2-table vec%0d pad_oe", v));
    end

    // back to plain port outputs
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000); wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0000); wr(3'd1, 16'h0000);

    // R5 byte enables
    wr(3'd0, 16'hA5C3, 2'b11);
    wr(3'd0, 16'h1234, 2'b01);
    rd(3'd0, rv); chk(rv, 16'hA534, "R5 low byte only");
    wr(3'd0, 16'hFFFF, 2'b10);
    rd(3'd0, rv); chk(rv, 16'hFF34, "R5 high byte only");
    wr(3'd0, 16'h0000, 2'b00);
    rd(3'd0, rv); chk(rv, 16'hFF34, "R5 no byte enabled");

    // R9 registered pad outputs
    wr(3'd0, 16'h0F0F);
    chk(pad_out, 16'hFF34, "R9 pad_out before next edge");
    step();
    chk(pad_out, 16'h0F0F, "R9 pad_out after next edge");

    // R6 mixed read
    @(negedge clk) pad_in = 16'hABCD;
    wr(3'd1, 16'hFF00);
    step(); step();
    rd(3'd0, rv); chk(rv, 16'hAB0F, "R6 mixed data read");
    wr(3'd4, 16'h5A5A);
    rd(3'd4, rv); chk(rv, 16'h5A5A, "R6 fsel1 readback");
    wr(3'd4, 16'h0000);
    rd(3'd6, rv); chk(rv, 16'h0000, "R6 set offset reads zero");

    // R8 synchronizer latency
    chk(periph_in, 16'hABCD, "R8 periph_in settled");
    @(negedge clk) pad_in = 16'h1357;
    step(); chk(periph_in, 16'hABCD, "R8 one edge not yet");
    step(); chk(periph_in, 16'h1357, "R8 two edges visible");

    // R7 set/clear read-modify-write (dir still FF00, latch 0F0F)
    wr(3'd6, 16'h0010);
    wr(3'd1, 16'h0000);
    rd(3'd0, rv); chk(rv, 16'h131F, "R7 set copies pin level");
    step(); chk(pad_out, 16'h131F, "R7 set visible on pads");
    wr(3'd7, 16'h0003);
    rd(3'd0, rv); chk(rv, 16'h131C, "R7 clear");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule